// File: doc/BRIEF.md
# Size-Merging Integer ALU Stage

This block is the integer execution stage of a microcoded processor. It runs eight operations: add, add with carry, subtract, subtract with borrow, AND, OR, XOR and a flag-conditional move. The first source is a 64-bit register value. The second operand is either a second register value or an 8-bit immediate, and a select input picks which one is used. An operand-size input chooses 1, 2, 4 or 8 bytes. Only that many low bytes of the previous destination value are replaced by the result. The bytes above are passed through unchanged.

The block keeps a five-bit condition-flag register. Each operation offers new flag values, and a per-operation enable mask decides which flag bits are actually written. Carry-in for the carry and borrow operations, and the predicate for the conditional move, are taken from this register. An operation presented in one cycle therefore sees the flags written by the operation in the cycle before it. The arithmetic is combinational. Result, valid and flags are registered, so the block accepts one operation per cycle.

Top module: `size_merge_alu`

## Requirements
- R1: After synchronous reset, `out_valid`, `result` and `flags` are all zero.
- R2: `out_valid` is high in the cycle after `in_valid` was sampled high, and low otherwise. `result` and `flags` for that operation appear in the same cycle as `out_valid`.
- R3: When `use_imm` is 1, the second operand is `imm8` zero-extended to 64 bits, and `src_b` has no effect on the result.
- R4: `size_sel` 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. `result` equals `old_dst` with only that many low bytes replaced by the operation's value.
- R5: The `op` encoding is 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR and 7 conditional move. Add-with-carry adds the current CF. Subtract-with-borrow subtracts CF as well as the second operand.
- R6: The flag bits are CF bit 0, PF bit 1, ZF bit 2, SF bit 3 and OF bit 4. All are evaluated at the operand size:
  - ZF is set when the sized result is zero.
  - SF is the sized result's top bit.
  - PF is set when the low result byte has an even number of ones.
  - CF is the carry out of the sized add, or the borrow of the sized subtract.
  - OF is signed overflow at the sized width.
- R7: Only flag bits whose `flag_en` bit is 1 are written. With `flag_en` zero, the flags keep their value.
- R8: For AND, OR and XOR, CF and OF become 0 when enabled.
- R9: The conditional move tests `cond` against the current flags. `cond[3:1]` selects the predicate: 0 OF, 1 CF, 2 ZF, 3 CF or ZF, 4 SF, 5 PF, 6 SF xor OF, 7 ZF or (SF xor OF). `cond[0]` inverts it.
- R10: When the move's predicate is true, the second operand is merged into `old_dst` at the operand size. When it is false, `result` equals `old_dst` unchanged. In both cases the flags are never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| use_imm | input | 1 | Select immediate as second operand |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second register source |
| imm8 | input | 8 | Immediate operand |
| old_dst | input | 64 | Previous destination value |
| size_sel | input | 2 | Operand size code |
| flag_en | input | 5 | Flag write-enable mask |
| cond | input | 4 | Condition code for the move |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Merged destination value |
| flags | output | 5 | Condition-flag register |

## Verification
Every result, and every flag update, is due exactly one clock after the operation is sampled, because there is a single register stage between the inputs and the outputs. A driver task applies each operation at a falling edge and queues the expected value and flag word, which it computes from a reference flag state it keeps itself. A monitor pops the queue at the next falling edge, when `out_valid` must be high, and compares. Any output that arrives with nothing queued, and any entry still queued at the end, counts as a failure. Back-to-back carry and borrow chains check that the flags written by one operation feed the next operation one cycle later.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_CMOV = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_ZF  = 2;
  localparam int FL_SF  = 3;
  localparam int FL_OF  = 4;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
  parameter int DW    = 64,
  parameter int IMM_W = 8
) (
  input  logic             use_imm,
  input  logic [DW-1:0]    src_b,
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    opnd_b
);
  assign opnd_b = use_imm ? {{(DW-IMM_W){1'b0}}, imm} : src_b;
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DW   = 64,
  parameter int SZ_N = 4,
  parameter int SZ_W = 2
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic [SZ_W-1:0]   size,
  input  logic [FLAG_W-1:0] flags_q,
  output logic [DW-1:0]     value,
  output logic [FLAG_W-1:0] flags_new
);
  logic            is_sub, is_logic, cin;
  logic [DW-1:0]   bx, sum_full, logic_val;
  logic [SZ_N-1:0] carry_k, zero_k, rsgn_k, asgn_k, bsgn_k;
  logic            c_sel, z_sel, rs_sel, as_sel, bs_sel;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBB);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    unique case (op)
      OP_ADC:  cin = flags_q[FL_CF];
      OP_SUB:  cin = 1'b1;
      OP_SBB:  cin = ~flags_q[FL_CF];
      default: cin = 1'b0;
    endcase
    bx = is_sub ? ~b : b;
    unique case (op)
      OP_AND:  logic_val = a & b;
      OP_OR:   logic_val = a | b;
      default: logic_val = a ^ b;
    endcase
  end

  assign sum_full = a + bx + DW'(cin);

  always_comb begin
    if (op == OP_CMOV)   value = b;
    else if (is_logic)   value = logic_val;
    else                 value = sum_full;
  end

  // One narrow adder per operand size yields that size's carry-out.
  for (genvar k = 0; k < SZ_N; k++) begin : g_lane
    localparam int W = 8 << k;
    logic [W:0] lane_sum;
    assign lane_sum   = {1'b0, a[W-1:0]} + {1'b0, bx[W-1:0]} + (W+1)'(cin);
    assign carry_k[k] = lane_sum[W];
    assign zero_k[k]  = (value[W-1:0] == '0);
    assign rsgn_k[k]  = value[W-1];
    assign asgn_k[k]  = a[W-1];
    assign bsgn_k[k]  = bx[W-1];
  end

  assign c_sel  = carry_k[size];
  assign z_sel  = zero_k[size];
  assign rs_sel = rsgn_k[size];
  assign as_sel = asgn_k[size];
  assign bs_sel = bsgn_k[size];

  always_comb begin
    flags_new        = '0;
    flags_new[FL_ZF] = z_sel;
    flags_new[FL_SF] = rs_sel;
    flags_new[FL_PF] = ~^value[7:0];
    if (!is_logic) begin
      flags_new[FL_CF] = is_sub ? ~c_sel : c_sel;
      flags_new[FL_OF] = (as_sel == bs_sel) && (rs_sel != as_sel);
    end
  end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
  import alu_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] fl,
  output logic              pass
);
  logic pred;
  always_comb begin
    unique case (cond[3:1])
      3'd0: pred = fl[FL_OF];
      3'd1: pred = fl[FL_CF];
      3'd2: pred = fl[FL_ZF];
      3'd3: pred = fl[FL_CF] | fl[FL_ZF];
      3'd4: pred = fl[FL_SF];
      3'd5: pred = fl[FL_PF];
      3'd6: pred = fl[FL_SF] ^ fl[FL_OF];
      default: pred = fl[FL_ZF] | (fl[FL_SF] ^ fl[FL_OF]);
    endcase
  end
  assign pass = pred ^ cond[0];
endmodule

// File: rtl/alu_merge.sv
module alu_merge #(
  parameter int DW   = 64,
  parameter int SZ_W = 2
) (
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   new_val,
  input  logic [SZ_W-1:0] size,
  output logic [DW-1:0]   merged
);
  localparam int NB = DW / 8;
  logic [NB:0] nbytes;
  assign nbytes = (NB+1)'(1) << size;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign merged[8*i +: 8] = ((NB+1)'(i) < nbytes) ? new_val[8*i +: 8]
                                                    : old_val[8*i +: 8];
  end
endmodule

// File: rtl/size_merge_alu.sv
module size_merge_alu
  import alu_pkg::*;
#(
  parameter int DW    = 64,
  parameter int IMM_W = 8,
  parameter int CC_W  = 4,
  localparam int SZ_N = $clog2(DW / 8) + 1,
  localparam int SZ_W = $clog2(SZ_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              use_imm,
  input  logic [DW-1:0]     src_a,
  input  logic [DW-1:0]     src_b,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [DW-1:0]     old_dst,
  input  logic [SZ_W-1:0]   size_sel,
  input  logic [FLAG_W-1:0] flag_en,
  input  logic [CC_W-1:0]   cond,
  output logic              out_valid,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flags
);
  alu_op_e           op_e;
  logic [DW-1:0]     opnd_b, value, merged;
  logic [FLAG_W-1:0] flags_new;
  logic              cond_pass;

  assign op_e = alu_op_e'(op);

  alu_opnd_sel #(.DW(DW), .IMM_W(IMM_W)) u_sel (
    .use_imm(use_imm), .src_b(src_b), .imm(imm8), .opnd_b(opnd_b)
  );

  alu_exec #(.DW(DW), .SZ_N(SZ_N), .SZ_W(SZ_W)) u_exec (
    .op(op_e), .a(src_a), .b(opnd_b), .size(size_sel), .flags_q(flags),
    .value(value), .flags_new(flags_new)
  );

  alu_cond u_cond (.cond(cond), .fl(flags), .pass(cond_pass));

  alu_merge #(.DW(DW), .SZ_W(SZ_W)) u_merge (
    .old_val(old_dst), .new_val(value), .size(size_sel), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (op_e == OP_CMOV) begin
          result <= cond_pass ? merged : old_dst;
        end else begin
          result <= merged;
          flags  <= (flags & ~flag_en) | (flags_new & flag_en);
        end
      end
    end
  end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [1:0]    size_sel,
  input logic [4:0]    flag_en,
  input logic [DW-1:0] old_dst,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic [4:0]    flags
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(flags));
  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flag_en == 5'd0) |=> $stable(flags));
  assert_move_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd7) |=> $stable(flags));
  assert_byte_merge_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'd0) |=> result[DW-1:8] == $past(old_dst[DW-1:8]));
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 3'd4 && op <= 3'd6 && flag_en[0] && flag_en[4])
      |=> (flags[0] == 1'b0 && flags[4] == 1'b0));
endmodule

bind size_merge_alu alu_chk #(.DW(DW)) u_alu_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size_sel(size_sel),
  .flag_en(flag_en), .old_dst(old_dst), .out_valid(out_valid),
  .result(result), .flags(flags)
);

// File: tb/test_size_merge_alu.sv
`timescale 1ns/1ps
module test_size_merge_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, old_dst = '0;
  logic [7:0]  imm8 = '0;
  logic [1:0]  size_sel = '0;
  logic [4:0]  flag_en = '0;
  logic [3:0]  cond = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [4:0]  flags;

  always #4 clk = ~clk;

  size_merge_alu i_size_merge_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm8(imm8), .old_dst(old_dst),
    .size_sel(size_sel), .flag_en(flag_en), .cond(cond),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  fl;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [4:0]  mfl = '0;

  function automatic bit cond_ok(input logic [3:0] c, input logic [4:0] f);
    bit p;
    case (c[3:1])
      3'd0: p = f[4];
      3'd1: p = f[0];
      3'd2: p = f[2];
      3'd3: p = f[0] | f[2];
      3'd4: p = f[3];
      3'd5: p = f[1];
      3'd6: p = f[3] ^ f[4];
      default: p = f[2] | (f[3] ^ f[4]);
    endcase
    return p ^ c[0];
  endfunction

  task automatic issue(input logic [2:0] o, input bit im, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] i8,
                       input logic [63:0] od, input logic [1:0] sz,
                       input logic [4:0] en, input logic [3:0] cc, input string tag);
    int          w;
    logic [63:0] m, aa, bb, r;
    logic [64:0] full;
    bit          sa, sb, sr, ncf, ov, c;
    exp_t        e;
    @(negedge clk);
    in_valid = 1'b1; op = o; use_imm = im; src_a = a; src_b = b; imm8 = i8;
    old_dst = od; size_sel = sz; flag_en = en; cond = cc;
    w  = 8 << sz;
    m  = (sz == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
    aa = a & m;
    bb = (im ? {56'd0, i8} : b) & m;
    e.tag = tag;
    if (o == 3'd7) begin
      e.res = cond_ok(cc, mfl) ? ((od & ~m) | bb) : od;
      e.fl  = mfl;
    end else begin
      c = mfl[0];
      ncf = 1'b0; ov = 1'b0;
      sa = aa[w-1]; sb = bb[w-1];
      case (o)
        3'd0, 3'd1: begin
          full = {1'b0, aa} + {1'b0, bb} + 65'((o == 3'd1) ? c : 1'b0);
          r = full[63:0] & m;
          ncf = full[w];
          ov = (sa == sb) && (r[w-1] != sa);
        end
        3'd2, 3'd3: begin
          r = (aa - bb - 64'((o == 3'd3) ? c : 1'b0)) & m;
          ncf = ({1'b0, aa} < ({1'b0, bb} + 65'((o == 3'd3) ? c : 1'b0)));
          ov = (sa != sb) && (r[w-1] != sa);
        end
        3'd4: r = aa & bb;
        3'd5: r = aa | bb;
        default: r = aa ^ bb;
      endcase
      sr = r[w-1];
      mfl = (mfl & ~en) | ({ov, sr, (r == 64'd0), ~^r[7:0], ncf} & en);
      e.res = (od & ~m) | r;
      e.fl  = mfl;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected out_valid got 1 exp 0");
      end else begin
        e = sb_q.pop_front();
        total++;
        if (result !== e.res) begin
          bad++;
          $display("FAIL %s result got %h exp %h", e.tag, result, e.res);
        end
        total++;
        if (flags !== e.fl) begin
          bad++;
          $display("FAIL %s flags got %b exp %b", e.tag, flags, e.fl);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    total++; if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 out_valid got %b exp 0", out_valid); end
    total++; if (result !== 64'd0) begin bad++; $display("FAIL R1 result got %h exp 0", result); end
    total++; if (flags !== 5'd0) begin bad++; $display("FAIL R1 flags got %b exp 0", flags); end

    // R5 plain add, full width
    issue(3'd0, 0, 64'd5, 64'd7, 8'd0, 64'hAAAA, 2'd3, 5'h1F, 4'd0, "R5");
    // R3 R4 R6 byte add via immediate, carry out and zero, src_b ignored
    issue(3'd0, 1, 64'hFF, 64'hDEAD_BEEF, 8'd1, 64'h1122334455667788, 2'd0, 5'h1F, 4'd0, "R3");
    // R5 add-with-carry consumes CF=1 from previous op
    issue(3'd1, 0, 64'd1, 64'd1, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 5'h1F, 4'd0, "R5");
    // R6 subtract borrow at 16 bits
    issue(3'd2, 0, 64'h1_0000, 64'd1, 8'd0, 64'h5555_5555_5555_5555, 2'd1, 5'h1F, 4'd0, "R6");
    // R5 subtract-with-borrow uses CF=1
    issue(3'd3, 0, 64'd10, 64'd3, 8'd0, 64'd0, 2'd2, 5'h1F, 4'd0, "R5");
    // R6 signed overflow at 32 bits
    issue(3'd0, 0, 64'h7FFF_FFFF, 64'd1, 8'd0, 64'hFFFF_0000_0000_0000, 2'd2, 5'h1F, 4'd0, "R6");
    // R8 logic clears CF and OF
    issue(3'd0, 0, 64'hFF, 64'hFF, 8'd0, 64'd0, 2'd0, 5'h1F, 4'd0, "R6");
    issue(3'd4, 0, 64'hF0F0, 64'hFF00, 8'd0, 64'd0, 2'd1, 5'h1F, 4'd0, "R8");
    // R7 empty mask keeps flags
    issue(3'd5, 0, 64'h0, 64'h0, 8'd0, 64'd9, 2'd3, 5'h00, 4'd0, "R7");
    // R7 partial mask: only ZF written
    issue(3'd6, 0, 64'h1234, 64'h1234, 8'd0, 64'd0, 2'd3, 5'h04, 4'd0, "R7");
    // R9 R10 move passes on ZF=1 (cond 4), fails on not-ZF (cond 5)
    issue(3'd7, 0, 64'd0, 64'hCAFE_F00D, 8'd0, 64'h0123_4567_89AB_CDEF, 2'd1, 5'h1F, 4'd4, "R9");
    issue(3'd7, 0, 64'd0, 64'hCAFE_F00D, 8'd0, 64'h0123_4567_89AB_CDEF, 2'd1, 5'h1F, 4'd5, "R10");
    issue(3'd7, 1, 64'd0, 64'd0, 8'h5A, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 5'h1F, 4'd14, "R9");
    idle(2);
    // back-to-back mixed traffic across all ops, sizes and conditions (R4 R5 R6 R9)
    for (int i = 0; i < 400; i++) begin
      issue(3'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom), {$urandom, $urandom}, 2'($urandom), 5'($urandom),
            4'($urandom), "R4");
      if ((i % 37) == 0) idle(1);
    end
    idle(4);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing outputs got %0d pending exp 0", sb_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule